// File: doc/BRIEF.md
# Quad-Rail Supply Fault Sequencer

This block turns the comparator results for four supply rails into two shared active-low fault pins, one for undervoltage and one for overvoltage. For each rail there is a high-tap bit (1 when the high tap is above threshold) and a low-tap bit (1 when the low tap is above threshold). Rails 1 and 2 are always read as positive supplies. A 2-bit polarity code decides whether rails 3 and 4 are read as negative supplies. For a negative rail the meaning of the two taps is swapped.

Every comparator bit first passes through a glitch filter. The filtered per-rail flags are then ORed into one undervoltage request and one overvoltage request. Each output has a release timer. The timer holds the output low for a timeout after the last fault clears, and it starts over when a new fault arrives. A bypass input skips the timeout.

A supply-lockout flag forces undervoltage low and blocks overvoltage. The mode input has one of two meanings, chosen at build time by a parameter. In latch mode it acts as an active-low overvoltage latch enable and clear. In disable mode it forces both outputs high, except that lockout still drives undervoltage low.

Top module: `rail_fault_sequencer`

## Requirements
- R1: During and right after reset, uv_n is 0 and ov_n is 1. The undervoltage release timer then starts counting, so with healthy inputs uv_n rises about TIMEOUT cycles after reset.
- R2: On a positive rail, cmp_hi=0 requests undervoltage and cmp_lo=1 requests overvoltage. uv_n is low when any rail requests undervoltage, and ov_n is low when any rail requests overvoltage.
- R3: On a negative rail, cmp_lo=1 requests undervoltage and cmp_hi=0 requests overvoltage. The pol_sel codes are: 2'b00 makes rails 3 and 4 negative; 2'b01 makes rail 3 positive and rail 4 negative; 2'b10 and 2'b11 make both positive.
- R4: While supply_lock is 1, ov_n is 1.
- R5: While supply_lock is 1, uv_n is 0. After lockout ends, uv_n stays low for the full timeout before it releases.
- R6: A comparator change that lasts fewer than FILT_CYCLES consecutive cycles has no effect on either output.
- R7: After the last filtered fault clears, the output stays low for TIMEOUT cycles. A new fault during that window restarts the timeout from zero once the fault clears.
- R8: With tmo_bypass=1, an output releases a few cycles after the filtered fault clears, without waiting for the timeout.
- R9: In latch mode with mode_in=0, an overvoltage output stays low after its fault clears, and this includes a timeout that was already running when mode_in fell. The output releases only after mode_in returns to 1 and the remaining timeout has elapsed.
- R10: In latch mode with mode_in=1, overvoltage releases with the same timeout as undervoltage.
- R11: In disable mode with mode_in=1, both outputs are 1 whatever the comparator bits are. supply_lock still drives uv_n low, and uv_n returns high within two cycles after lockout ends, with no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_hi | input | 4 | High-tap comparator bits, 1 = above threshold, bit i is rail i+1 |
| cmp_lo | input | 4 | Low-tap comparator bits, 1 = above threshold |
| pol_sel | input | 2 | Encoded three-state polarity select for rails 3 and 4 |
| supply_lock | input | 1 | Supply undervoltage lockout flag |
| tmo_bypass | input | 1 | 1 = release outputs without the timeout |
| mode_in | input | 1 | Overvoltage latch enable/clear (latch mode) or disable (disable mode) |
| uv_n | output | 1 | Undervoltage fault, active low, registered |
| ov_n | output | 1 | Overvoltage fault, active low, registered |

## Verification
Four properties are checked on every cycle: ov_n stays high under lockout, uv_n stays low under sustained lockout, both outputs stay clean under disable, and a latched overvoltage state holds and drives the pin. Other behaviours can only be shown by the bench scenarios, because they depend on exact cycle counts over long windows. These are the polarity swap for each pol_sel code, glitch rejection, the timeout length and its restart, bypass release, latch release after mode_in returns to 1, and the instant release of lockout under disable.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  localparam int RAILS = 4;

  typedef enum logic [1:0] {
    SEL_BOTH_NEG = 2'b00,
    SEL_MIXED    = 2'b01,
    SEL_BOTH_POS = 2'b10,
    SEL_SPARE    = 2'b11
  } pol_sel_e;

  // 1 when the given rail index (0-based) is read as a negative supply
  function automatic logic rail_is_neg(input int idx, input logic [1:0] sel);
    logic neg;
    neg = 1'b0;
    if (idx == 2) neg = (sel == SEL_BOTH_NEG);
    if (idx == 3) neg = (sel == SEL_BOTH_NEG) || (sel == SEL_MIXED);
    return neg;
  endfunction
endpackage

// File: rtl/rfs_deglitch.sv
module rfs_deglitch #(
  parameter int WINDOW  = 4,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      clean <= RST_VAL;
      run   <= '0;
    end else if (raw == clean) begin
      run <= '0;
    end else if (run == LAST) begin
      clean <= raw;
      run   <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/rfs_polarity.sv
module rfs_polarity
  import rfs_pkg::*;
(
  input  logic [RAILS-1:0] hi_f,
  input  logic [RAILS-1:0] lo_f,
  input  logic [1:0]       sel,
  output logic [RAILS-1:0] uv_req,
  output logic [RAILS-1:0] ov_req
);
  for (genvar r = 0; r < RAILS; r++) begin : g_rail
    logic neg;
    always_comb begin
      neg       = rail_is_neg(r, sel);
      uv_req[r] = neg ? lo_f[r]  : ~hi_f[r];
      ov_req[r] = neg ? ~hi_f[r] : lo_f[r];
    end
  end
endmodule

// File: rtl/rfs_release_timer.sv
module rfs_release_timer #(
  parameter int TIMEOUT     = 16,
  parameter bit RST_ACTIVE  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic fault,
  input  logic clear,
  input  logic hold,
  input  logic bypass,
  output logic active
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= RST_ACTIVE;
      cnt    <= '0;
    end else if (clear) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (fault) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active && !hold) begin
      if (bypass || cnt == LAST) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rail_fault_sequencer.sv
module rail_fault_sequencer
  import rfs_pkg::*;
#(
  parameter int FILT_CYCLES = 250,
  parameter int TIMEOUT     = 1000000,
  parameter bit LATCH_MODE  = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] cmp_hi,
  input  logic [3:0] cmp_lo,
  input  logic [1:0] pol_sel,
  input  logic       supply_lock,
  input  logic       tmo_bypass,
  input  logic       mode_in,
  output logic       uv_n,
  output logic       ov_n
);
  logic [RAILS-1:0] hi_f, lo_f, uv_req, ov_req;
  logic uv_active, ov_active, disabled, ov_hold;

  for (genvar r = 0; r < RAILS; r++) begin : g_filt
    rfs_deglitch #(.WINDOW(FILT_CYCLES), .RST_VAL(1'b1)) u_hi (
      .clk(clk), .rst(rst), .raw(cmp_hi[r]), .clean(hi_f[r]));
    rfs_deglitch #(.WINDOW(FILT_CYCLES), .RST_VAL(1'b0)) u_lo (
      .clk(clk), .rst(rst), .raw(cmp_lo[r]), .clean(lo_f[r]));
  end

  rfs_polarity u_pol (
    .hi_f(hi_f), .lo_f(lo_f), .sel(pol_sel),
    .uv_req(uv_req), .ov_req(ov_req));

  assign ov_hold  = LATCH_MODE && !mode_in;
  assign disabled = !LATCH_MODE && mode_in;

  rfs_release_timer #(.TIMEOUT(TIMEOUT), .RST_ACTIVE(1'b1)) u_uv_tmr (
    .clk(clk), .rst(rst), .fault((|uv_req) || supply_lock),
    .clear(1'b0), .hold(1'b0), .bypass(tmo_bypass), .active(uv_active));

  rfs_release_timer #(.TIMEOUT(TIMEOUT), .RST_ACTIVE(1'b0)) u_ov_tmr (
    .clk(clk), .rst(rst), .fault(|ov_req),
    .clear(supply_lock), .hold(ov_hold), .bypass(tmo_bypass),
    .active(ov_active));

  always_ff @(posedge clk) begin
    if (rst) begin
      uv_n <= 1'b0;
      ov_n <= 1'b1;
    end else if (disabled) begin
      uv_n <= !supply_lock;
      ov_n <= 1'b1;
    end else begin
      uv_n <= !uv_active;
      ov_n <= !(ov_active && !supply_lock);
    end
  end
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
  parameter bit LATCH_MODE = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic supply_lock,
  input logic mode_in,
  input logic uv_n,
  input logic ov_n,
  input logic ov_active
);
  a_r4_ov_quiet_in_lock: assert property (@(posedge clk) disable iff (rst)
    $past(supply_lock) |-> ov_n);

  a_r5_uv_low_in_lock: assert property (@(posedge clk) disable iff (rst)
    ($past(supply_lock, 2) && $past(supply_lock)) |-> !uv_n);

  if (LATCH_MODE) begin : g_latch
    a_r9_latch_holds: assert property (@(posedge clk) disable iff (rst)
      (ov_active && !mode_in && !supply_lock) |=> ov_active);
    a_r2_ov_pin_tracks_state: assert property (@(posedge clk) disable iff (rst)
      ($past(ov_active) && !$past(supply_lock)) |-> !ov_n);
  end else begin : g_dis
    a_r11_disable_clean: assert property (@(posedge clk) disable iff (rst)
      ($past(mode_in) && !$past(supply_lock)) |-> (uv_n && ov_n));
  end
endmodule

bind rail_fault_sequencer rfs_checker #(.LATCH_MODE(LATCH_MODE)) u_rfs_checker (
  .clk(clk), .rst(rst), .supply_lock(supply_lock), .mode_in(mode_in),
  .uv_n(uv_n), .ov_n(ov_n), .ov_active(ov_active));

// File: tb/rail_fault_sequencer_bench.sv
module rail_fault_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 4;
  localparam int TMO  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] cmp_hi = 4'hF;
  logic [3:0] cmp_lo = 4'h0;
  logic [1:0] pol_sel = 2'b10;
  logic supply_lock = 1'b0;
  logic tmo_bypass = 1'b0;
  logic mode_l = 1'b1;
  logic mode_d = 1'b0;
  logic uv_n, ov_n, uv_n_d, ov_n_d;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_fault_sequencer #(.FILT_CYCLES(FILT), .TIMEOUT(TMO), .LATCH_MODE(1'b1))
    u_rail_fault_sequencer (
      .clk(clk), .rst(rst), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .pol_sel(pol_sel),
      .supply_lock(supply_lock), .tmo_bypass(tmo_bypass), .mode_in(mode_l),
      .uv_n(uv_n), .ov_n(ov_n));

  rail_fault_sequencer #(.FILT_CYCLES(FILT), .TIMEOUT(TMO), .LATCH_MODE(1'b0))
    u_rail_fault_sequencer_dis (
      .clk(clk), .rst(rst), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .pol_sel(pol_sel),
      .supply_lock(supply_lock), .tmo_bypass(tmo_bypass), .mode_in(mode_d),
      .uv_n(uv_n_d), .ov_n(ov_n_d));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    tick(3);
    chk("R1 uv_n in reset", uv_n, 1'b0);
    chk("R1 ov_n in reset", ov_n, 1'b1);
    rst = 1'b0;
    tick(TMO - 1);
    chk("R1 uv_n held by timeout", uv_n, 1'b0);
    tick(4);
    chk("R1 uv_n released", uv_n, 1'b1);
    chk("R1 ov_n idle", ov_n, 1'b1);
  endtask

  task automatic t_pos_map();
    tmo_bypass = 1'b1;
    cmp_hi[0] = 1'b0; tick(FILT + 3);
    chk("R2 hi low gives uv", uv_n, 1'b0);
    chk("R2 hi low no ov", ov_n, 1'b1);
    cmp_hi[0] = 1'b1; tick(FILT + 3);
    cmp_lo[1] = 1'b1; tick(FILT + 3);
    chk("R2 lo high gives ov", ov_n, 1'b0);
    chk("R2 lo high no uv", uv_n, 1'b1);
    cmp_lo[1] = 1'b0; tick(FILT + 3);
  endtask

  task automatic t_polarity();
    tmo_bypass = 1'b1;
    pol_sel = 2'b00; tick(2);
    cmp_hi[2] = 1'b0; tick(FILT + 3);
    chk("R3 sel00 rail3 hi low gives ov", ov_n, 1'b0);
    chk("R3 sel00 rail3 hi low no uv", uv_n, 1'b1);
    cmp_hi[2] = 1'b1; tick(FILT + 3);
    pol_sel = 2'b01; tick(2);
    cmp_hi[2] = 1'b0; tick(FILT + 3);
    chk("R3 sel01 rail3 positive uv", uv_n, 1'b0);
    chk("R3 sel01 rail3 positive no ov", ov_n, 1'b1);
    cmp_hi[2] = 1'b1; tick(FILT + 3);
    cmp_lo[3] = 1'b1; tick(FILT + 3);
    chk("R3 sel01 rail4 negative uv", uv_n, 1'b0);
    chk("R3 sel01 rail4 negative no ov", ov_n, 1'b1);
    cmp_lo[3] = 1'b0; tick(FILT + 3);
    pol_sel = 2'b11; tick(2);
    cmp_lo[3] = 1'b1; tick(FILT + 3);
    chk("R3 sel11 rail4 positive ov", ov_n, 1'b0);
    chk("R3 sel11 rail4 positive no uv", uv_n, 1'b1);
    cmp_lo[3] = 1'b0; tick(FILT + 3);
    pol_sel = 2'b10; tick(2);
  endtask

  task automatic t_glitch();
    tmo_bypass = 1'b0;
    cmp_hi[1] = 1'b0; tick(FILT - 1);
    cmp_hi[1] = 1'b1; tick(10);
    chk("R6 short hi glitch ignored", uv_n, 1'b1);
    cmp_lo[0] = 1'b1; tick(FILT - 1);
    cmp_lo[0] = 1'b0; tick(10);
    chk("R6 short lo glitch ignored", ov_n, 1'b1);
  endtask

  task automatic t_timeout();
    tmo_bypass = 1'b0;
    cmp_hi[0] = 1'b0; tick(FILT + 3);
    chk("R7 fault asserts uv", uv_n, 1'b0);
    cmp_hi[0] = 1'b1; tick(FILT + TMO - 1);
    chk("R7 held through timeout", uv_n, 1'b0);
    tick(4);
    chk("R7 released after timeout", uv_n, 1'b1);
    cmp_hi[0] = 1'b0; tick(FILT + 3);
    cmp_hi[0] = 1'b1; tick(FILT + 10);
    cmp_hi[0] = 1'b0; tick(FILT + 3);
    cmp_hi[0] = 1'b1; tick(FILT + TMO - 1);
    chk("R7 restart keeps uv low", uv_n, 1'b0);
    tick(4);
    chk("R7 release after restart", uv_n, 1'b1);
  endtask

  task automatic t_bypass();
    tmo_bypass = 1'b1;
    cmp_lo[2] = 1'b1; tick(FILT + 3);
    chk("R8 ov asserted", ov_n, 1'b0);
    cmp_lo[2] = 1'b0; tick(FILT + 3);
    chk("R8 ov released without timeout", ov_n, 1'b1);
    tmo_bypass = 1'b0;
  endtask

  task automatic t_lockout();
    cmp_lo[0] = 1'b1; tick(FILT + 3);
    chk("R4 ov before lockout", ov_n, 1'b0);
    supply_lock = 1'b1; tick(2);
    chk("R4 ov forced high in lockout", ov_n, 1'b1);
    chk("R5 uv low in lockout", uv_n, 1'b0);
    cmp_lo[0] = 1'b0; tick(FILT + 3);
    chk("R4 ov stays high in lockout", ov_n, 1'b1);
    supply_lock = 1'b0; tick(TMO - 1);
    chk("R5 uv held by timeout after lockout", uv_n, 1'b0);
    tick(4);
    chk("R5 uv released after lockout timeout", uv_n, 1'b1);
  endtask

  task automatic t_latch();
    mode_l = 1'b0;
    cmp_lo[0] = 1'b1; tick(FILT + 3);
    chk("R9 ov asserted", ov_n, 1'b0);
    cmp_lo[0] = 1'b0; tick(3 * TMO);
    chk("R9 ov latched", ov_n, 1'b0);
    mode_l = 1'b1; tick(TMO - 2);
    chk("R9 ov held by timeout after clear", ov_n, 1'b0);
    tick(5);
    chk("R9 ov released after clear", ov_n, 1'b1);
    cmp_lo[0] = 1'b1; tick(FILT + 3);
    cmp_lo[0] = 1'b0; tick(FILT + 8);
    mode_l = 1'b0; tick(3 * TMO);
    chk("R9 latch during running timeout", ov_n, 1'b0);
    mode_l = 1'b1; tick(TMO + 3);
    chk("R9 release after mid-timeout latch", ov_n, 1'b1);
  endtask

  task automatic t_transparent();
    mode_l = 1'b1;
    cmp_lo[1] = 1'b1; tick(FILT + 3);
    chk("R10 ov asserted", ov_n, 1'b0);
    cmp_lo[1] = 1'b0; tick(FILT + TMO - 1);
    chk("R10 ov held by timeout", ov_n, 1'b0);
    tick(4);
    chk("R10 ov released after timeout", ov_n, 1'b1);
  endtask

  task automatic t_disable();
    mode_d = 1'b1;
    cmp_hi[0] = 1'b0; cmp_lo[1] = 1'b1; tick(FILT + 5);
    chk("R11 uv clean under disable", uv_n_d, 1'b1);
    chk("R11 ov clean under disable", ov_n_d, 1'b1);
    supply_lock = 1'b1; tick(2);
    chk("R11 lockout asserts uv", uv_n_d, 1'b0);
    chk("R11 lockout leaves ov high", ov_n_d, 1'b1);
    supply_lock = 1'b0; tick(2);
    chk("R11 uv released without timeout", uv_n_d, 1'b1);
    cmp_hi[0] = 1'b1; cmp_lo[1] = 1'b0; tick(FILT + 3);
  endtask

  initial begin
    t_reset();
    t_pos_map();
    t_polarity();
    t_glitch();
    t_timeout();
    t_bypass();
    t_lockout();
    t_latch();
    t_transparent();
    t_disable();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R0 watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule